// File: doc/BRIEF.md
# Glitch-free two-source clock selector with gate

The block picks one of two clocks, which may be unrelated in frequency and phase, and drives it onto a single output clock. A change of selection never produces a runt pulse or a glitch. The clock that was driving the output is let go only on one of its own falling edges. The output then stays low until the newly chosen clock has had a falling edge of its own, and after that the output follows it.

A gate input parks the output low without affecting which source is selected. The gate is taken into each source's domain on that source's falling edge, so a pulse that is already under way is never cut short. A parameter chooses whether the gate input enables the output when high or when low.

Each source has its own path. A path synchronises its request on the falling edge of its own clock. It raises its request only while the other path holds no claim, and that interlock keeps the two paths from driving the output at the same time.

Top module: `glitchless_clk_sel`

## Requirements
- R1: While rst_n is low across falling edges of both sources, path 0 is claimed and path 1 is idle. After release with pick = 0 and the gate active, clk_out equals src_clk0.
- R2: Once a selection has settled with the gate active, pick = 0 makes clk_out equal src_clk0 and pick = 1 makes clk_out equal src_clk1.
- R3: After pick changes, clk_out keeps following the previously selected clock. A high phase in progress is never shortened, and the old clock is released only at one of its falling edges, after SYNC_STAGES of them.
- R4: Once the old source is released, clk_out stays low until the new source has had a falling edge, and then follows the new source. The two paths are never active at the same time.
- R5: With the gate inactive, clk_out is held low. A selection change still completes while the gate is inactive.
- R6: A gate change takes effect at the next falling edge of the source in question. Deasserting the gate during a high phase leaves that pulse intact. Asserting it during a high phase produces no output until the next rising edge.
- R7: With EN_ACTIVE_HIGH = 1, gate_en = 1 enables the output. With EN_ACTIVE_HIGH = 0, gate_en = 0 enables it.
- R8: Every high pulse on clk_out is at least as long as the shorter of the two source high phases. Every low pulse is at least as long as the shorter of the two source low phases.
- R9: If pick returns to its earlier value before a handover completes, the block settles on the value pick finally holds, and R8 still holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled on the falling edge of each source |
| src_clk0 | input | 1 | Source clock selected when pick = 0 |
| src_clk1 | input | 1 | Source clock selected when pick = 1 |
| pick | input | 1 | Source selection (0: src_clk0, 1: src_clk1) |
| gate_en | input | 1 | Output gate, polarity set by EN_ACTIVE_HIGH |
| clk_out | output | 1 | Selected and gated clock |

## Verification
Steady selections of each source are compared sample by sample against the chosen clock, and this separates a swapped or stuck selection from correct following. Handover traces in both directions classify every sample as old-follow, low gap or new-follow, and these expose an early release, an overlap of the two sources or a missing low gap. Gate changes placed in the middle of a high phase separate sampling at the falling edge from sampling at any edge. Pick is also flipped back after delays of 1 to 12 ns, and randomly mixed pick and gate settings are run, while a pulse-width monitor catches any runt these sequences cause.

// File: rtl/gclk_sel_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helpers for the glitch-free clock selector.
// Assumes exactly two sources; the type widths follow NUM_SRC.
package gclk_sel_pkg;

    localparam int unsigned NUM_SRC = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Converts the raw gate pin into an "enabled" level for the chosen polarity.
    function automatic logic enable_level(input logic raw, input bit active_high);
        return active_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/gclk_sel_claim_sync.sv
`timescale 1ns/1ps
// Falling-edge synchroniser for one path's request. It also produces a
// registered "claim" flag that is high whenever any stage holds a request,
// including the stage that drives the path enable. The other path reads the
// flag as its interlock.
// Assumes STAGES >= 2. Reset is synchronous, active low, on the falling edge.
module gclk_sel_claim_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_raw,
    output logic active,
    output logic claimed
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic [LAST:0] chain_d;
    logic          claim_q;

    // Next contents of the chain: shift the raw request in at stage 0.
    always_comb chain_d = {chain_q[LAST-1:0], req_raw};

    // Advance the chain and record whether any stage will hold a request.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
            claim_q <= RESET_VAL;
        end else begin
            chain_q <= chain_d;
            claim_q <= |chain_d;
        end
    end

    assign active  = chain_q[LAST];
    assign claimed = claim_q;

endmodule

// File: rtl/gclk_sel_path.sv
`timescale 1ns/1ps
// One source path. It requests the output only when chosen and while the
// other path holds no claim. The path enable and the gate level change only
// on this source's falling edges, so the AND gate below switches only while
// the source is low.
// Assumes the gate input is quasi-static relative to this clock.
module gclk_sel_path
    import gclk_sel_pkg::*;
#(
    parameter int unsigned STAGES         = 2,
    parameter bit          RESET_ON       = 1'b0,
    parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chosen,
    input  logic other_claim,
    input  logic en_raw,
    output logic on,
    output logic claim,
    output logic en_seen,
    output logic gated
);

    logic req;
    logic en_q;

    // Interlock: request only if selected and the other path holds no claim.
    always_comb req = chosen & ~other_claim;

    gclk_sel_claim_sync #(
        .STAGES   (STAGES),
        .RESET_VAL(RESET_ON)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_raw(req),
        .active (on),
        .claimed(claim)
    );

    // Capture the gate level while the source is low (falling edge).
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= enable_level(en_raw, EN_ACTIVE_HIGH);
    end

    assign en_seen = en_q;
    assign gated   = clk & on & en_q;

endmodule

// File: rtl/glitchless_clk_sel.sv
`timescale 1ns/1ps
// Glitch-free selector between two unrelated clocks, with an output gate.
// Each source has its own path. The paths are cross-coupled through their
// claim flags, so at most one of them drives the output at any time.
// Assumes rst_n is held low across several falling edges of both sources.
module glitchless_clk_sel
    import gclk_sel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
    input  logic rst_n,
    input  logic src_clk0,
    input  logic src_clk1,
    input  logic pick,
    input  logic gate_en,
    output logic clk_out
);

    src_vec_t srcs;
    src_vec_t chosen;
    src_vec_t path_on;
    src_vec_t path_claim;
    src_vec_t path_en;
    src_vec_t path_clk;

    // Gather the sources and decode the selection into per-path requests.
    always_comb begin
        srcs   = {src_clk1, src_clk0};
        chosen = {pick, ~pick};
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_path
        gclk_sel_path #(
            .STAGES        (SYNC_STAGES),
            .RESET_ON      (g == 0),
            .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)
        ) u_path (
            .clk        (srcs[g]),
            .rst_n      (rst_n),
            .chosen     (chosen[g]),
            .other_claim(path_claim[NUM_SRC-1-g]),
            .en_raw     (gate_en),
            .on         (path_on[g]),
            .claim      (path_claim[g]),
            .en_seen    (path_en[g]),
            .gated      (path_clk[g])
        );
    end

    // Merge the gated paths; the interlock leaves at most one of them active.
    assign clk_out = |path_clk;

endmodule

// File: rtl/glitchless_clk_sel_chk.sv
`timescale 1ns/1ps
// Property checker for the clock selector, bound to every instance.
// Values are sampled at each source's falling edge. The sampled (preponed)
// values are those of the high phase that just ended.
module glitchless_clk_sel_chk (
    input logic       rst_n,
    input logic       src_clk0,
    input logic       src_clk1,
    input logic       clk_out,
    input logic [1:0] on_q,
    input logic [1:0] en_q
);

    // R1
    reset_claim_chk: assert property (@(negedge src_clk0)
        !rst_n |=> (on_q[0] && !on_q[1]));

    // R4
    path_excl_a_chk: assert property (@(negedge src_clk0) disable iff (!rst_n)
        $onehot0(on_q));

    // R4
    path_excl_b_chk: assert property (@(negedge src_clk1) disable iff (!rst_n)
        $onehot0(on_q));

    // R4
    idle_low_a_chk: assert property (@(negedge src_clk0) disable iff (!rst_n)
        (on_q == 2'b00) |-> !clk_out);

    // R4
    idle_low_b_chk: assert property (@(negedge src_clk1) disable iff (!rst_n)
        (on_q == 2'b00) |-> !clk_out);

    // R2
    follow_a_chk: assert property (@(negedge src_clk0) disable iff (!rst_n)
        (on_q[0] && en_q[0]) |-> clk_out);

    // R2
    follow_b_chk: assert property (@(negedge src_clk1) disable iff (!rst_n)
        (on_q[1] && en_q[1]) |-> clk_out);

    // R5
    gated_a_chk: assert property (@(negedge src_clk0) disable iff (!rst_n)
        (on_q[0] && !en_q[0]) |-> !clk_out);

    // R5
    gated_b_chk: assert property (@(negedge src_clk1) disable iff (!rst_n)
        (on_q[1] && !en_q[1]) |-> !clk_out);

endmodule

bind glitchless_clk_sel glitchless_clk_sel_chk u_chk (
    .rst_n   (rst_n),
    .src_clk0(src_clk0),
    .src_clk1(src_clk1),
    .clk_out (clk_out),
    .on_q    (path_on),
    .en_q    (path_en)
);

// File: tb/glitchless_clk_sel_test.sv
`timescale 1ns/1ps
module glitchless_clk_sel_test;

    logic src_clk0 = 1'b0;
    logic src_clk1 = 1'b0;
    logic rst_n    = 1'b0;
    logic pick     = 1'b0;
    logic gate_en  = 1'b1;
    logic gate_lo  = 1'b0;
    logic clk_out;
    logic clk_out_lo;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    real t_rise = -1.0;
    real t_fall = -1.0;
    real min_hi = 1.0e9;
    real min_lo = 1.0e9;
    bit  mon    = 1'b0;

    // 200 MHz main source, unrelated second source.
    always #2.5 src_clk0 = ~src_clk0;
    always #3.5 src_clk1 = ~src_clk1;

    glitchless_clk_sel #(.SYNC_STAGES(2), .EN_ACTIVE_HIGH(1'b1)) uut (
        .rst_n(rst_n), .src_clk0(src_clk0), .src_clk1(src_clk1),
        .pick(pick), .gate_en(gate_en), .clk_out(clk_out)
    );

    glitchless_clk_sel #(.SYNC_STAGES(2), .EN_ACTIVE_HIGH(1'b0)) uut_lo (
        .rst_n(rst_n), .src_clk0(src_clk0), .src_clk1(src_clk1),
        .pick(pick), .gate_en(gate_lo), .clk_out(clk_out_lo)
    );

    // Pulse-width monitor for R8.
    always @(posedge clk_out) begin
        if (mon && t_fall >= 0.0 && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime;
    end
    always @(negedge clk_out) begin
        if (mon && t_rise >= 0.0 && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        t_fall = $realtime;
    end

    function automatic logic exp_out(input logic p, input logic en_on,
                                     input logic a, input logic b);
        return en_on ? (p ? b : a) : 1'b0;
    endfunction

    task automatic report(input bit ok, input string req, input string what,
                          input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare an output against its expected clock every 0.5 ns (edge-free grid).
    task automatic window(input string req, input bit lo_inst, input int n);
        int bad = 0;
        repeat (n) begin
            #0.5;
            if (lo_inst) begin
                if (clk_out_lo !== exp_out(pick, ~gate_lo, src_clk0, src_clk1)) bad++;
            end else begin
                if (clk_out !== exp_out(pick, gate_en, src_clk0, src_clk1)) bad++;
            end
        end
        report(bad == 0, req, "mismatched samples", bad, 0);
    endtask

    // Put the bench back on the 0.25 ns offset grid.
    task automatic align();
        @(posedge src_clk0);
        #0.25;
    endtask

    // R4 trace: old follow, then a low gap, then new follow, never out of order.
    task automatic handover(input logic to_pick);
        int ph  = 0;
        int bad = 0;
        pick = to_pick;
        repeat (80) begin
            logic a, b, o;
            #0.5;
            a = to_pick ? src_clk0 : src_clk1;
            b = to_pick ? src_clk1 : src_clk0;
            o = clk_out;
            if (o && !((a && ph == 0) || b)) bad++;
            if (ph >= 1 && o && a && !b) bad++;
            if (ph == 2 && b && !o) bad++;
            if (ph == 0 && !o && a) ph = 1;
            if (o && b && !(a && ph == 0)) ph = 2;
        end
        report(bad == 0, "R4", "ordering violations", bad, 0);
        report(ph == 2, "R4", "final phase", ph, 2);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual 0 expected 1 completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2718);
        #0.25;
        #30;
        rst_n = 1'b1;

        // R1: reset leaves source 0 selected.
        window("R1", 1'b0, 100);
        t_rise = -1.0; t_fall = -1.0; mon = 1'b1;

        // R2: both steady selections.
        pick = 1'b1; #40; window("R2", 1'b0, 80);
        pick = 1'b0; #40; window("R2", 1'b0, 80);

        // R3: a pick change during a high phase does not cut the pulse.
        align();
        #0.25; pick = 1'b1; #0.5;
        report(clk_out === 1'b1, "R3", "clk_out mid-high after pick change", clk_out, 1);
        @(posedge src_clk0); #0.5;
        report(clk_out === 1'b1, "R3", "clk_out before old release", clk_out, 1);
        align(); #40;
        window("R3", 1'b0, 60);

        // R4: traced handovers in both directions.
        handover(1'b0); #10;
        handover(1'b1); #10;
        handover(1'b0);
        align();

        // R5: gate parks the output low; a handover still completes underneath.
        gate_en = 1'b0; #20; window("R5", 1'b0, 60);
        pick = 1'b1; #40; window("R5", 1'b0, 40);
        gate_en = 1'b1; #20; window("R5", 1'b0, 40);
        pick = 1'b0; #40;

        // R6: gate changes act only at the falling edge.
        align();
        gate_en = 1'b0; #0.5;
        report(clk_out === 1'b1, "R6", "pulse kept after mid-high disable", clk_out, 1);
        @(posedge src_clk0); #0.5;
        report(clk_out === 1'b0, "R6", "low after disable took effect", clk_out, 0);
        @(posedge src_clk0); #0.25;
        gate_en = 1'b1; #0.5;
        report(clk_out === 1'b0, "R6", "no pulse after mid-high enable", clk_out, 0);
        @(posedge src_clk0); #0.5;
        report(clk_out === 1'b1, "R6", "follows from next rising edge", clk_out, 1);
        align();

        // R7: active-low gate polarity on the second instance.
        gate_lo = 1'b1; #20; window("R7", 1'b1, 60);
        gate_lo = 1'b0; #20; window("R7", 1'b1, 60);

        // R9: pick returns before the handover completes.
        for (int d = 1; d <= 12; d++) begin
            pick = 1'b1; #(d); pick = 1'b0; #40;
            window("R9", 1'b0, 30);
        end
        pick = 1'b1; #40;
        for (int d = 1; d <= 12; d++) begin
            pick = 1'b0; #(d); pick = 1'b1; #40;
            window("R9", 1'b0, 30);
        end

        // Random mix of selections, brief flips and gate settings.
        for (int i = 0; i < 40; i++) begin
            logic np;
            np = logic'($urandom % 2);
            if ($urandom % 3 == 0) begin
                pick = ~np; #(($urandom % 8) + 1);
            end
            pick    = np;
            gate_en = logic'(($urandom % 4) != 0);
            gate_lo = logic'($urandom % 2);
            #40;
            window(gate_en ? "R2" : "R5", 1'b0, 40);
            window("R7", 1'b1, 20);
        end

        // R8: no runt pulses anywhere in the run.
        report(min_hi >= 2.49, "R8", "shortest high pulse x100", int'(min_hi * 100.0), 250);
        report(min_lo >= 2.49, "R8", "shortest low pulse x100", int'(min_lo * 100.0), 250);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule